// File: doc/BRIEF.md
# Power-Up and Reconfiguration I/O Sequencer

This controller decides what the user pins and user registers of a programmable logic device do while its core supply comes up and while a new configuration pattern is swapped in live. While the supply is not good, every output is off with a weak pullup and the test port stays dead. Once the supply is good, the block asks a copy engine to move the stored pattern from nonvolatile storage into the working cells. A programmed part then initializes its registers and releases its outputs. An erased part keeps its outputs off but opens the test port, so that it can be programmed.

A live pattern switch reuses the same protective pin state: outputs are disabled and pulled up until the copy engine reports completion. A cycle-count timeout guards both copy phases. When it expires, the block parks the part in the safe hold state, with the test port open, instead of waiting forever.

Top module: `pwrseq_ctrl`

## Requirements
- R1: During reset the outputs are out_disable=1, pullup_en=1, jtag_en=0, copy_req=0, reg_init=0, ready=0 (the quiescent pattern).
- R2: If supply_ok is low at a clock edge, the outputs show the quiescent pattern after that edge, whatever the state was before.
- R3: In the quiescent state, supply_ok high at an edge starts the load phase. After that edge copy_req=1 and jtag_en=1, and the outputs stay disabled with pullups.
- R4: copy_done during a copy phase with erased=0 leads to one initialize cycle (reg_init=1, outputs still disabled). The running state follows: ready=1, out_disable=0, pullup_en=0.
- R5: reg_init is high for exactly one cycle. ready rises in the cycle right after it.
- R6: copy_done during a copy phase with erased=1 leads to the safe hold state: out_disable=1, pullup_en=1, jtag_en=1, copy_req=0, ready=0. The state holds until supply_ok drops or reconf_req starts a reconfiguration.
- R7: jtag_en is 1 in every state except the quiescent one, including the running state.
- R8: reconf_req in the running state makes the outputs after that edge ready=0, out_disable=1, pullup_en=1 and copy_req=1. The phase then ends as in R4 or R6.
- R9: copy_req stays high for at most TIMEOUT_CYC consecutive cycles. If copy_done has not arrived by the TIMEOUT_CYC-th cycle, the block enters the safe hold state. copy_done in that last cycle still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Core supply is above the safe threshold |
| erased | input | 1 | No user pattern is stored |
| reconf_req | input | 1 | Request a live pattern switch |
| copy_done | input | 1 | Copy engine finished moving the pattern |
| out_disable | output | 1 | Global output disable |
| pullup_en | output | 1 | Weak pullup enable on all user pins |
| jtag_en | output | 1 | Test port enable |
| copy_req | output | 1 | Request the pattern copy |
| reg_init | output | 1 | One-cycle global register initialize |
| ready | output | 1 | Pins and registers in user operation |

## Verification
Two events can land in the same cycle: the copy engine finishing and the timeout expiring. The bench sweeps the arrival of copy_done over every cycle of the copy window, for both the erased and the programmed case. This includes the last allowed cycle, where completion must win, and the cycles past it, where the safe hold state must appear after exactly TIMEOUT_CYC cycles. Each sweep ends with a supply drop from a different state, which shows that the drop takes precedence over everything else.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_QUIET = 3'd0,
    ST_LOAD  = 3'd1,
    ST_INIT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_SWAP  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic out_disable;
    logic pullup_en;
    logic jtag_en;
    logic copy_req;
    logic reg_init;
    logic ready;
  } pin_ctl_t;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int unsigned LIMIT = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (run) cnt_d = cnt_q + 1'b1;
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       erased,
  input  logic       reconf_req,
  input  logic       copy_done,
  input  logic       expired,
  output seq_state_e state_q
);
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = ST_QUIET;
    end else begin
      unique case (state_q)
        ST_QUIET: state_d = ST_LOAD;
        ST_LOAD, ST_SWAP: begin
          if (copy_done)    state_d = erased ? ST_HOLD : ST_INIT;
          else if (expired) state_d = ST_HOLD;
        end
        ST_INIT: state_d = ST_RUN;
        ST_RUN:  if (reconf_req) state_d = ST_SWAP;
        ST_HOLD: if (reconf_req) state_d = ST_SWAP;
        default: state_d = ST_QUIET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_QUIET;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pwrseq_outdec.sv
module pwrseq_outdec
  import pwrseq_pkg::*;
(
  input  seq_state_e state,
  output pin_ctl_t   ctl
);
  always_comb begin
    ctl = '{out_disable: 1'b1, pullup_en: 1'b1, jtag_en: 1'b1,
            copy_req: 1'b0, reg_init: 1'b0, ready: 1'b0};
    unique case (state)
      ST_QUIET: ctl.jtag_en = 1'b0;
      ST_LOAD, ST_SWAP: ctl.copy_req = 1'b1;
      ST_INIT: ctl.reg_init = 1'b1;
      ST_RUN: begin
        ctl.out_disable = 1'b0;
        ctl.pullup_en   = 1'b0;
        ctl.ready       = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic erased,
  input  logic reconf_req,
  input  logic copy_done,
  output logic out_disable,
  output logic pullup_en,
  output logic jtag_en,
  output logic copy_req,
  output logic reg_init,
  output logic ready
);
  seq_state_e state;
  pin_ctl_t   ctl;
  logic       copying;
  logic       expired;

  assign copying = (state == ST_LOAD) || (state == ST_SWAP);

  pwrseq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (copying),
    .expired (expired)
  );

  pwrseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .erased     (erased),
    .reconf_req (reconf_req),
    .copy_done  (copy_done),
    .expired    (expired),
    .state_q    (state)
  );

  pwrseq_outdec u_dec (
    .state (state),
    .ctl   (ctl)
  );

  assign out_disable = ctl.out_disable;
  assign pullup_en   = ctl.pullup_en;
  assign jtag_en     = ctl.jtag_en;
  assign copy_req    = ctl.copy_req;
  assign reg_init    = ctl.reg_init;
  assign ready       = ctl.ready;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic erased,
  input logic copy_done,
  input logic out_disable,
  input logic pullup_en,
  input logic jtag_en,
  input logic copy_req,
  input logic reg_init,
  input logic ready
);
  localparam int unsigned RW = $clog2(TIMEOUT_CYC + 2);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (copy_req) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (out_disable && pullup_en && !jtag_en && !ready && !copy_req));

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !jtag_en) |=> (copy_req && jtag_en && out_disable));

  p_init_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_init |=> !reg_init);

  p_ready_after_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(reg_init));

  p_pins_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!out_disable && !pullup_en && jtag_en));

  p_erased_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && copy_req && copy_done && erased) |=>
      (out_disable && pullup_en && jtag_en && !ready && !reg_init));

  p_copy_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |-> (run_len < RW'(TIMEOUT_CYC)));
endmodule

bind pwrseq_ctrl pwrseq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .erased      (erased),
  .copy_done   (copy_done),
  .out_disable (out_disable),
  .pullup_en   (pullup_en),
  .jtag_en     (jtag_en),
  .copy_req    (copy_req),
  .reg_init    (reg_init),
  .ready       (ready)
);

// File: tb/pwrseq_ctrl_tb.sv
`timescale 1ns/1ps
module pwrseq_ctrl_tb;
  localparam int T = 8;
  localparam logic [5:0] P_QUIET = 6'b110000;
  localparam logic [5:0] P_COPY  = 6'b111100;
  localparam logic [5:0] P_INIT  = 6'b111010;
  localparam logic [5:0] P_RUN   = 6'b001001;
  localparam logic [5:0] P_HOLD  = 6'b111000;

  logic clk = 1'b0;
  logic rst_n, supply_ok, erased, reconf_req, copy_done;
  logic out_disable, pullup_en, jtag_en, copy_req, reg_init, ready;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwrseq_ctrl #(.TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .erased(erased),
    .reconf_req(reconf_req), .copy_done(copy_done),
    .out_disable(out_disable), .pullup_en(pullup_en), .jtag_en(jtag_en),
    .copy_req(copy_req), .reg_init(reg_init), .ready(ready)
  );

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {out_disable, pullup_en, jtag_en, copy_req, reg_init, ready};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; erased = 1'b0;
    reconf_req = 1'b0; copy_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", P_QUIET);
    rst_n = 1'b1;

    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d <= T + 1; d++) begin
        supply_ok = 1'b0; reconf_req = 1'b0; copy_done = 1'b0;
        step();
        check("R2 supply drop", P_QUIET);
        supply_ok = 1'b1; erased = e[0];
        step();
        for (int k = 0; k < T; k++) begin
          check(k == 0 ? "R3 load start" : "R9 copy window", P_COPY);
          copy_done = (k == d);
          step();
          copy_done = 1'b0;
          if (k == d) break;
        end
        if (d >= T) begin
          check("R9 timeout to hold", P_HOLD);
        end else if (e == 1) begin
          check("R6 erased hold", P_HOLD);
          step(); step();
          check("R6 hold stable R7", P_HOLD);
          reconf_req = 1'b1;
          step();
          reconf_req = 1'b0;
          check("R6 reconf from hold", P_COPY);
        end else begin
          check("R4 R5 init pulse", P_INIT);
          step();
          check("R4 R5 R7 running", P_RUN);
          reconf_req = 1'b1;
          step();
          reconf_req = 1'b0;
          check("R8 swap start", P_COPY);
          if (d == 1) begin
            for (int k = 1; k < T; k++) begin
              step();
              check("R9 swap window", P_COPY);
            end
            step();
            check("R9 swap timeout", P_HOLD);
          end else begin
            copy_done = 1'b1;
            step();
            copy_done = 1'b0;
            check("R8 swap init", P_INIT);
            step();
            check("R8 swap run", P_RUN);
          end
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule